// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a three-wire serial audio stream (a bit clock, a word clock and one data line) and turns it into parallel 24-bit left and right samples. All three serial lines are sampled in the system clock domain. The block finds bit-clock rising edges by comparing each sample with the one before, and finds word boundaries by watching for changes of the word-clock level at those edges. Every word is MSB first in two's complement.

Four static mode pins choose the framing and the channel routing. The framings are I2S, left-justified, and right-justified with 16 or 24 bits. The routing is stereo, left channel to both outputs, or right channel to both outputs. One code selects a filter-bypass framing: 24-bit right-justified words marked by a fast word clock, with each word sent to both outputs. After each completed stereo frame the block gives a one-cycle strobe, and a flag output shows whether bypass framing is active.

Top module: `sai_rx`

## Requirements
- R1: While rst_n is low, left_o and right_o read zero and valid_o and bypass_o read 0.
- R2: Data and word-clock level are taken at rising edges of bclk_i only, and each word is assembled MSB first.
- R3: With fmt_i=00, the MSB comes one bit clock after the word-clock change. A low word clock marks the left channel, and the first 24 bits of each word are kept.
- R4: With fmt_i=01, the MSB comes at the same bit clock as the word-clock change. A high word clock marks the left channel, and the first 24 bits are kept.
- R5: With fmt_i=10, only the last 16 bits before the word-clock change are kept and are sign-extended from bit 15 to 24 bits. A high word clock marks the left channel.
- R6: With fmt_i=11 (outside the bypass code), the last 24 bits before the word-clock change are kept. A high word clock marks the left channel.
- R7: valid_o pulses for exactly one cycle after a right word completes, and only when a left word was captured before it. Words that end at the first word-clock change after reset are discarded, and so are right words with no left word before them.
- R8: With mono_i=0 the outputs carry left and right separately. With mono_i=1 and chsel_i=0 both outputs carry the left word, and with mono_i=1 and chsel_i=1 both outputs carry the right word.
- R9: With mono_i=0 and chsel_i=1, the codes 00, 01 and 10 give the same framing and stereo routing as with chsel_i=0.
- R10: The code mono_i=0, chsel_i=1, fmt_i=11 raises bypass_o. Each falling word-clock edge then ends a word, the last 24 bits before it are sent to both outputs, and valid_o pulses once.
- R11: left_o and right_o hold their values in every cycle where valid_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all serial inputs are sampled on it |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Serial bit clock |
| wclk_i | input | 1 | Word clock (channel select, or word marker in bypass) |
| sdata_i | input | 1 | Serial data, MSB first |
| mono_i | input | 1 | Mono routing select |
| chsel_i | input | 1 | Channel / variant select |
| fmt_i | input | 2 | Framing code |
| left_o | output | 24 | Left sample of the last frame |
| right_o | output | 24 | Right sample of the last frame |
| valid_o | output | 1 | One-cycle strobe when new samples are presented |
| bypass_o | output | 1 | High while bypass framing is selected |

## Verification
Each framing runs on 32-bit slots, and the unused bits of each slot are filled with ones. The ones would show up in the result if the block kept the wrong window, so the test tells a one-bit I2S offset from left-justified alignment and tells the last 16 bits from the last 24 bits. The sample patterns are full-scale negative, full-scale positive, zero, and mixed words with bit 15 set and clear, which tests sign extension and rejection of the upper bits. The mono, chsel-variant and bypass codes are run with different left and right values, so a routing mistake or a swapped channel level gives a wrong output word.

// File: rtl/sai_pkg.sv
package sai_pkg;

    typedef enum logic [1:0] {
        FMT_I2S  = 2'd0,
        FMT_LJ   = 2'd1,
        FMT_RJ16 = 2'd2,
        FMT_RJ24 = 2'd3
    } sai_fmt_e;

    typedef enum logic [1:0] {
        ROUTE_STEREO = 2'd0,
        ROUTE_MONO_L = 2'd1,
        ROUTE_MONO_R = 2'd2
    } sai_route_e;

    typedef struct packed {
        sai_fmt_e   fmt;
        sai_route_e route;
        logic       bypass;
    } sai_mode_t;

endpackage

// File: rtl/sai_mode_dec.sv
module sai_mode_dec
    import sai_pkg::*;
(
    input  logic       mono_i,
    input  logic       chsel_i,
    input  logic [1:0] fmt_i,
    output sai_mode_t  mode_o
);

    always_comb begin
        mode_o.bypass = !mono_i && chsel_i && (fmt_i == 2'b11);
        mode_o.fmt    = sai_fmt_e'(fmt_i);
        if (!mono_i) begin
            mode_o.route = ROUTE_STEREO;
        end else if (chsel_i) begin
            mode_o.route = ROUTE_MONO_R;
        end else begin
            mode_o.route = ROUTE_MONO_L;
        end
        if (mode_o.bypass) begin
            mode_o.fmt   = FMT_RJ24;
            mode_o.route = ROUTE_MONO_L;
        end
    end

endmodule

// File: rtl/sai_bclk_edge.sv
module sai_bclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    output logic rise_o
);

    logic bclk_d;
    logic bclk_q;

    always_comb begin
        bclk_d = bclk_i;
        rise_o = bclk_i && !bclk_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q <= 1'b1;
        end else begin
            bclk_q <= bclk_d;
        end
    end

endmodule

// File: rtl/sai_word_cap.sv
module sai_word_cap
    import sai_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int SHORT_W  = 16,
    parameter int MAX_SLOT = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise_i,
    input  logic                wclk_i,
    input  logic                sdata_i,
    input  sai_fmt_e            fmt_i,
    input  logic                bypass_i,
    output logic                wd_stb_o,
    output logic                wd_left_o,
    output logic [SAMPLE_W-1:0] wd_data_o
);

    localparam int CNT_W = $clog2(MAX_SLOT + 2);
    localparam int EXT_W = SAMPLE_W - SHORT_W;

    typedef struct packed {
        logic                wprev;
        logic                started;
        logic                framed;
        logic [CNT_W-1:0]    cnt;
        logic [SAMPLE_W-1:0] acc;
        logic [SAMPLE_W-1:0] sh;
        logic                stb;
        logic                left;
        logic [SAMPLE_W-1:0] data;
    } cap_t;

    cap_t cap_d;
    cap_t cap_q;

    always_comb begin
        logic                boundary;
        logic                deliver;
        logic                is_i2s;
        logic                msb_al;
        logic                place;
        int                  tgt;
        logic [SAMPLE_W-1:0] acc_upd;
        logic [SAMPLE_W-1:0] word_rj;

        cap_d     = cap_q;
        cap_d.stb = 1'b0;
        is_i2s    = (fmt_i == FMT_I2S);
        msb_al    = (fmt_i == FMT_I2S) || (fmt_i == FMT_LJ);
        boundary  = cap_q.started && (wclk_i != cap_q.wprev);
        deliver   = 1'b0;
        acc_upd   = cap_q.acc;

        if (is_i2s) begin
            place = (cap_q.cnt != '0);
            tgt   = SAMPLE_W - int'(cap_q.cnt);
        end else begin
            place = !boundary;
            tgt   = SAMPLE_W - 1 - int'(cap_q.cnt);
        end

        for (int i = 0; i < SAMPLE_W; i++) begin
            if (place && (tgt == i)) begin
                acc_upd[i] = sdata_i;
            end
        end

        if (fmt_i == FMT_RJ16) begin
            word_rj = {{EXT_W{cap_q.sh[SHORT_W-1]}}, cap_q.sh[SHORT_W-1:0]};
        end else begin
            word_rj = cap_q.sh;
        end

        if (rise_i) begin
            cap_d.started = 1'b1;
            cap_d.wprev   = wclk_i;
            cap_d.sh      = {cap_q.sh[SAMPLE_W-2:0], sdata_i};
            if (boundary) begin
                cap_d.framed = 1'b1;
                deliver      = cap_q.framed && (!bypass_i || (cap_q.wprev && !wclk_i));
                if (deliver) begin
                    cap_d.stb  = 1'b1;
                    cap_d.data = msb_al ? acc_upd : word_rj;
                    cap_d.left = is_i2s ? !cap_q.wprev : cap_q.wprev;
                end
                cap_d.cnt = CNT_W'(1);
                cap_d.acc = '0;
                if (!is_i2s) begin
                    cap_d.acc[SAMPLE_W-1] = sdata_i;
                end
            end else begin
                cap_d.acc = acc_upd;
                if (cap_q.cnt != '1) begin
                    cap_d.cnt = cap_q.cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign wd_stb_o  = cap_q.stb;
    assign wd_left_o = cap_q.left;
    assign wd_data_o = cap_q.data;

endmodule

// File: rtl/sai_frame_asm.sv
module sai_frame_asm
    import sai_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wd_stb_i,
    input  logic                wd_left_i,
    input  logic [SAMPLE_W-1:0] wd_data_i,
    input  sai_route_e          route_i,
    input  logic                bypass_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o,
    output logic                bypass_o
);

    typedef struct packed {
        logic [SAMPLE_W-1:0] hold;
        logic                have;
        logic [SAMPLE_W-1:0] l;
        logic [SAMPLE_W-1:0] r;
        logic                v;
        logic                byp;
    } asm_t;

    asm_t asm_d;
    asm_t asm_q;

    always_comb begin
        asm_d     = asm_q;
        asm_d.v   = 1'b0;
        asm_d.byp = bypass_i;
        if (wd_stb_i) begin
            if (bypass_i) begin
                asm_d.l = wd_data_i;
                asm_d.r = wd_data_i;
                asm_d.v = 1'b1;
            end else if (wd_left_i) begin
                asm_d.hold = wd_data_i;
                asm_d.have = 1'b1;
            end else if (asm_q.have) begin
                asm_d.have = 1'b0;
                asm_d.v    = 1'b1;
                unique case (route_i)
                    ROUTE_MONO_L: begin
                        asm_d.l = asm_q.hold;
                        asm_d.r = asm_q.hold;
                    end
                    ROUTE_MONO_R: begin
                        asm_d.l = wd_data_i;
                        asm_d.r = wd_data_i;
                    end
                    default: begin
                        asm_d.l = asm_q.hold;
                        asm_d.r = wd_data_i;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asm_q <= '0;
        end else begin
            asm_q <= asm_d;
        end
    end

    assign left_o   = asm_q.l;
    assign right_o  = asm_q.r;
    assign valid_o  = asm_q.v;
    assign bypass_o = asm_q.byp;

endmodule

// File: rtl/sai_rx.sv
module sai_rx
    import sai_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int SHORT_W  = 16,
    parameter int MAX_SLOT = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_i,
    input  logic                wclk_i,
    input  logic                sdata_i,
    input  logic                mono_i,
    input  logic                chsel_i,
    input  logic [1:0]          fmt_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o,
    output logic                bypass_o
);

    sai_mode_t           mode;
    logic                rise;
    logic                wd_stb;
    logic                wd_left;
    logic [SAMPLE_W-1:0] wd_data;

    sai_mode_dec u_dec (
        .mono_i  (mono_i),
        .chsel_i (chsel_i),
        .fmt_i   (fmt_i),
        .mode_o  (mode)
    );

    sai_bclk_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .bclk_i (bclk_i),
        .rise_o (rise)
    );

    sai_word_cap #(
        .SAMPLE_W (SAMPLE_W),
        .SHORT_W  (SHORT_W),
        .MAX_SLOT (MAX_SLOT)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise),
        .wclk_i    (wclk_i),
        .sdata_i   (sdata_i),
        .fmt_i     (mode.fmt),
        .bypass_i  (mode.bypass),
        .wd_stb_o  (wd_stb),
        .wd_left_o (wd_left),
        .wd_data_o (wd_data)
    );

    sai_frame_asm #(
        .SAMPLE_W (SAMPLE_W)
    ) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wd_stb_i  (wd_stb),
        .wd_left_i (wd_left),
        .wd_data_i (wd_data),
        .route_i   (mode.route),
        .bypass_i  (mode.bypass),
        .left_o    (left_o),
        .right_o   (right_o),
        .valid_o   (valid_o),
        .bypass_o  (bypass_o)
    );

endmodule

// File: rtl/sai_rx_chk.sv
module sai_rx_chk #(
    parameter int SAMPLE_W = 24,
    parameter int SHORT_W  = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mono_i,
    input logic                chsel_i,
    input logic [1:0]          fmt_i,
    input logic [SAMPLE_W-1:0] left_o,
    input logic [SAMPLE_W-1:0] right_o,
    input logic                valid_o,
    input logic                bypass_o
);

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R7

    AST_MONO_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && mono_i) |-> (left_o == right_o)); // R8

    AST_BYPASS_BOTH_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && bypass_o) |-> (left_o == right_o)); // R10

    AST_BYPASS_FLAG_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (!mono_i && chsel_i && fmt_i == 2'b11) |=> bypass_o); // R10

    AST_BYPASS_FLAG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mono_i || !chsel_i || fmt_i != 2'b11) |=> !bypass_o); // R10

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(left_o) && $stable(right_o))); // R11

    AST_SHORT_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && fmt_i == 2'b10) |->
        ((&left_o[SAMPLE_W-1:SHORT_W-1]) || !(|left_o[SAMPLE_W-1:SHORT_W-1]))); // R5

endmodule

bind sai_rx sai_rx_chk #(
    .SAMPLE_W (SAMPLE_W),
    .SHORT_W  (SHORT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mono_i   (mono_i),
    .chsel_i  (chsel_i),
    .fmt_i    (fmt_i),
    .left_o   (left_o),
    .right_o  (right_o),
    .valid_o  (valid_o),
    .bypass_o (bypass_o)
);

// File: tb/sim_sai_rx.sv
module sim_sai_rx;

    localparam int CLK_PERIOD = 10;
    localparam int SLOT       = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b1;
    logic        wclk = 1'b0;
    logic        sdat = 1'b0;
    logic        mono = 1'b0;
    logic        chsel = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic [23:0] left_o;
    logic [23:0] right_o;
    logic        valid_o;
    logic        bypass_o;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [23:0] l;
        logic [23:0] r;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sai_rx u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_i   (bclk),
        .wclk_i   (wclk),
        .sdata_i  (sdat),
        .mono_i   (mono),
        .chsel_i  (chsel),
        .fmt_i    (fmt),
        .left_o   (left_o),
        .right_o  (right_o),
        .valid_o  (valid_o),
        .bypass_o (bypass_o)
    );

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected frame per strobe
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && valid_o) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    fails++;
                    $display("FAIL R7 unexpected strobe actual=%h expected=none", {left_o, right_o});
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.tag, {left_o, right_o}, {e.l, e.r});
                end
            end
        end
    end

    function automatic logic bit_of(input int kind, input int j, input logic [23:0] v);
        case (kind)
            0: return (j >= 1 && j <= 24) ? v[24-j] : 1'b1;
            1: return (j < 24) ? v[23-j] : 1'b1;
            2: return (j >= 16) ? v[31-j] : 1'b1;
            default: return (j >= 8) ? v[31-j] : 1'b1;
        endcase
    endfunction

    function automatic logic [23:0] word_of(input int kind, input logic [23:0] v);
        if (kind == 2) return {{8{v[15]}}, v[15:0]};
        return v;
    endfunction

    task automatic send_bit(input logic w, input logic d);
        @(negedge clk);
        bclk = 1'b0;
        wclk = w;
        sdat = d;
        @(negedge clk);
        @(negedge clk);
        bclk = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_slot(input int kind, input logic w, input logic [23:0] v);
        for (int j = 0; j < SLOT; j++) begin
            send_bit(w, bit_of(kind, j, v));
        end
    endtask

    // route: 0 stereo, 1 left to both, 2 right to both
    task automatic send_frame(input int kind, input int route, input logic [23:0] l,
                              input logic [23:0] r, input bit push, input string tag);
        logic wl;
        wl = (kind == 0) ? 1'b0 : 1'b1;
        if (push) begin
            exp_t e;
            e.tag = tag;
            case (route)
                1: begin e.l = word_of(kind, l); e.r = word_of(kind, l); end
                2: begin e.l = word_of(kind, r); e.r = word_of(kind, r); end
                default: begin e.l = word_of(kind, l); e.r = word_of(kind, r); end
            endcase
            exp_q.push_back(e);
        end
        send_slot(kind, wl, l);
        send_slot(kind, !wl, r);
    endtask

    task automatic send_byp_word(input logic [23:0] v, input bit push);
        if (push) begin
            exp_t e;
            e.tag = "R10";
            e.l = v;
            e.r = v;
            exp_q.push_back(e);
        end
        for (int j = 0; j < SLOT; j++) begin
            send_bit((j >= 16), (j >= 8) ? v[31-j] : 1'b1);
        end
    endtask

    task automatic do_reset(input logic m, input logic c, input logic [1:0] f, input logic exp_byp,
                            input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        mono  = m;
        chsel = c;
        fmt   = f;
        bclk  = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", {left_o, right_o}, 48'h0);
        check("R1", {46'h0, valid_o, bypass_o}, 48'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(tag, {47'h0, bypass_o}, {47'h0, exp_byp});
    endtask

    task automatic run_mode(input logic m, input logic c, input logic [1:0] f, input int kind,
                            input int route, input string tag);
        exp_t last;
        do_reset(m, c, f, 1'b0, tag);
        send_frame(kind, route, 24'h3C3C3C, 24'hC3C3C3, 1'b0, tag);
        send_frame(kind, route, 24'h800000, 24'h7FFFFF, 1'b1, tag);
        send_frame(kind, route, 24'h000000, 24'hA5C3E1, 1'b1, tag);
        send_frame(kind, route, 24'h008001, 24'hFF7FFE, 1'b1, tag);
        last = exp_q[exp_q.size()-1];
        send_frame(kind, route, 24'h123456, 24'h654321, 1'b0, tag);
        check("R7", {16'h0, 32'(exp_q.size())}, 48'h0);
        exp_q.delete();
        // R11: the trailing frame leaves the outputs untouched without a strobe
        check("R11", {left_o, right_o}, {last.l, last.r});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R3 R2: I2S stereo
        run_mode(1'b0, 1'b0, 2'b00, 0, 0, "R3 R2");
        // R4: left-justified stereo
        run_mode(1'b0, 1'b0, 2'b01, 1, 0, "R4");
        // R5: right-justified 16-bit stereo
        run_mode(1'b0, 1'b0, 2'b10, 2, 0, "R5");
        // R6: right-justified 24-bit stereo
        run_mode(1'b0, 1'b0, 2'b11, 3, 0, "R6");
        // R9: chsel variant codes behave like the plain ones
        run_mode(1'b0, 1'b1, 2'b00, 0, 0, "R9");
        run_mode(1'b0, 1'b1, 2'b01, 1, 0, "R9");
        run_mode(1'b0, 1'b1, 2'b10, 2, 0, "R9");
        // R8: mono routing
        run_mode(1'b1, 1'b0, 2'b01, 1, 1, "R8");
        run_mode(1'b1, 1'b1, 2'b11, 3, 2, "R8");
        run_mode(1'b1, 1'b0, 2'b00, 0, 1, "R8");
        // R10: bypass framing
        do_reset(1'b0, 1'b1, 2'b11, 1'b1, "R10");
        send_byp_word(24'h800000, 1'b1);
        send_byp_word(24'h7FFFFF, 1'b1);
        send_byp_word(24'hA5C3E1, 1'b1);
        send_byp_word(24'h0F0F0F, 1'b0);
        check("R10", {16'h0, 32'(exp_q.size())}, 48'h0);
        check("R11", {left_o, right_o}, {24'hA5C3E1, 24'hA5C3E1});
        exp_q.delete();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule